// File: doc/BRIEF.md
# Variable-Width Load/Store Data Sequencer

This block moves a register value to or from a byte-wide memory port. It holds an accumulator and two index registers, each two bytes wide, plus a negative flag and a zero flag. A single start strobe launches one operation: a load into a chosen register, a store from a chosen register, or a store of zero. The caller also supplies a ready-made effective address and a width flag. In narrow (8-bit) mode the operation makes one byte access. In wide (16-bit) mode it makes two byte accesses on consecutive cycles, low byte first. A done pulse follows one cycle after the last access. Address calculation, instruction decode and cycle accounting belong to the caller.

The sequencer is a four-state machine. `ST_IDLE` waits for a start strobe (transition *accept*). `ST_LO` makes the access at the effective address. From there the *narrow-finish* transition leads to `ST_DONE`, and the *wide-continue* transition leads to `ST_HI`. `ST_HI` makes the access at the effective address plus one (transition *high-finish* to `ST_DONE`). `ST_DONE` raises done for one cycle (transition *retire* back to `ST_IDLE`). A load commits its register and flags on the clock edge that ends its last access.

Top module: `ldst_seq`

## Requirements
- R1: The `op` encoding is 00 for a load, 01 for a store, and 10 or 11 for a store of zero. The `tgt` encoding is 00 for the accumulator, 01 for X, and 10 or 11 for Y. With `narrow`=1, the block makes exactly one byte access at `ea` in the cycle after start is accepted, and raises `done` for one cycle in the following cycle.
- R2: With `narrow`=0, the low byte is accessed at `ea` in the first access cycle and the high byte at `ea`+1 in the next cycle. `done` follows one cycle later. A load reads through `mem_rd`. A store or store of zero writes through `mem_wr`. The two enables are never high together.
- R3: The address of the high-byte access is `ea`+1 modulo 2^AW, so 0xFFFF is followed by 0x0000.
- R4: After a load, `flag_n` equals bit 7 of the loaded byte in narrow mode and bit 15 of the loaded value in wide mode.
- R5: After a load, `flag_z` is 1 exactly when the loaded bytes of the active width are all zero.
- R6: A narrow load replaces only bits 7:0 of the target register and keeps its bits 15:8.
- R7: A store writes bits 7:0 of the target register first and, in wide mode, bits 15:8 second. It leaves every register, `flag_n` and `flag_z` unchanged.
- R8: A store of zero writes the value 0x00 in every write cycle, whatever the target register holds. It leaves registers and flags unchanged.
- R9: A start strobe that arrives in any state other than `ST_IDLE` is ignored. No extra access and no change of address or operation follows from it.
- R10: While `rst_n` is low at a clock edge, the block returns to `ST_IDLE`. It clears all registers and both flags, and drives no access and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (accepted only in idle) |
| op | input | 2 | 00 load, 01 store, 1x store zero |
| tgt | input | 2 | 00 accumulator, 01 X, 1x Y |
| narrow | input | 1 | 1 = one byte, 0 = two bytes |
| ea | input | AW | Effective address of the low byte |
| mem_addr | output | AW | Byte address of the current access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled in a read cycle |
| mem_rd | output | 1 | Read enable |
| mem_wr | output | 1 | Write enable |
| done | output | 1 | One-cycle completion pulse |
| acc_q | output | 16 | Accumulator |
| x_q | output | 16 | Index register X |
| y_q | output | 16 | Index register Y |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench uses a wide access at 0xFFFF, where a design without modular wrap would issue an out-of-range or wrong address. It checks a narrow load from a zero byte into a register whose high byte is nonzero: a design that tests or clears the full 16 bits would report Z=0 or wipe the high byte. It uses a wide load from two zero bytes and loads with the top bit set, which catch N being taken from the wrong bit. It holds the start strobe high through a busy operation and resets in the middle of an access; a design that restarts or keeps running would show an extra access or a stale register.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    localparam int BYTE_W = 8;
    localparam int NBYTES = 2;
    localparam int REG_W  = BYTE_W * NBYTES;
    localparam int NREGS  = 3;

    // register index from the target select: 0 acc, 1 X, 2/3 Y
    function automatic int unsigned reg_index(input logic [1:0] sel);
        return (sel[1]) ? 2 : int'(sel[0]);
    endfunction

endpackage

// File: rtl/ldst_fsm.sv
module ldst_fsm
    import ldst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       narrow_q,
    output seq_state_t state,
    output logic       accept,
    output logic       access,
    output logic       hi_phase,
    output logic       last_access,
    output logic       done
);

    seq_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LO;
            ST_LO:   state_nx = narrow_q ? ST_DONE : ST_HI;
            ST_HI:   state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        accept      = 1'b0;
        access      = 1'b0;
        hi_phase    = 1'b0;
        last_access = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE: accept = start;
            ST_LO: begin
                access      = 1'b1;
                last_access = narrow_q;
            end
            ST_HI: begin
                access      = 1'b1;
                hi_phase    = 1'b1;
                last_access = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ldst_addr.sv
module ldst_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] ea,
    input  logic          hi_phase,
    output logic [AW-1:0] mem_addr
);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (accept) base_q <= ea;
    end

    // the high byte sits one above the base, wrapping at 2^AW
    assign mem_addr = hi_phase ? AW'(base_q + AW'(1)) : base_q;

endmodule

// File: rtl/ldst_regs.sv
module ldst_regs
    import ldst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [1:0]        tgt_q,
    input  logic              narrow_q,
    input  logic [BYTE_W-1:0] byte_lo,
    input  logic [BYTE_W-1:0] byte_hi,
    output logic [REG_W-1:0]  acc_q,
    output logic [REG_W-1:0]  x_q,
    output logic [REG_W-1:0]  y_q,
    output logic [REG_W-1:0]  src_val,
    output logic              flag_n,
    output logic              flag_z
);

    logic [REG_W-1:0] bank [NREGS];
    int unsigned      sel_idx;

    assign sel_idx = reg_index(tgt_q);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (commit && (sel_idx == g)) begin
                bank[g][BYTE_W-1:0] <= byte_lo;
                if (!narrow_q) bank[g][REG_W-1:BYTE_W] <= byte_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (commit) begin
            flag_n <= narrow_q ? byte_lo[BYTE_W-1] : byte_hi[BYTE_W-1];
            flag_z <= narrow_q ? (byte_lo == '0) : ({byte_hi, byte_lo} == '0);
        end
    end

    assign acc_q   = bank[0];
    assign x_q     = bank[1];
    assign y_q     = bank[2];
    assign src_val = bank[sel_idx];

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
    import ldst_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [1:0]        tgt,
    input  logic              narrow,
    input  logic [AW-1:0]     ea,
    output logic [AW-1:0]     mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              done,
    output logic [REG_W-1:0]  acc_q,
    output logic [REG_W-1:0]  x_q,
    output logic [REG_W-1:0]  y_q,
    output logic              flag_n,
    output logic              flag_z
);

    seq_state_t        state;
    logic              accept, access, hi_phase, last_access;
    logic              load_q, zero_q, narrow_q;
    logic [1:0]        tgt_q;
    logic [BYTE_W-1:0] lo_byte_q;
    logic [BYTE_W-1:0] commit_lo, commit_hi;
    logic [REG_W-1:0]  src_val;
    logic              commit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= 1'b0;
            zero_q   <= 1'b0;
            narrow_q <= 1'b1;
            tgt_q    <= '0;
        end else if (accept) begin
            load_q   <= (op == 2'b00);
            zero_q   <= op[1];
            narrow_q <= narrow;
            tgt_q    <= tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         lo_byte_q <= '0;
        else if (mem_rd && !hi_phase)       lo_byte_q <= mem_rdata;
    end

    ldst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .narrow_q    (narrow_q),
        .state       (state),
        .accept      (accept),
        .access      (access),
        .hi_phase    (hi_phase),
        .last_access (last_access),
        .done        (done)
    );

    ldst_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .ea       (ea),
        .hi_phase (hi_phase),
        .mem_addr (mem_addr)
    );

    assign commit    = load_q && last_access;
    assign commit_lo = narrow_q ? mem_rdata : lo_byte_q;
    assign commit_hi = mem_rdata;

    ldst_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .tgt_q    (tgt_q),
        .narrow_q (narrow_q),
        .byte_lo  (commit_lo),
        .byte_hi  (commit_hi),
        .acc_q    (acc_q),
        .x_q      (x_q),
        .y_q      (y_q),
        .src_val  (src_val),
        .flag_n   (flag_n),
        .flag_z   (flag_z)
    );

    assign mem_rd    = access && load_q;
    assign mem_wr    = access && !load_q;
    assign mem_wdata = zero_q   ? '0 :
                       hi_phase ? src_val[REG_W-1:BYTE_W] : src_val[BYTE_W-1:0];

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          done,
    input logic          flag_n,
    input logic          flag_z,
    input logic          zero_q
);

    p_no_dual_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_done_follows_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_rd || mem_wr) && !mem_rd && !mem_wr));

    p_hi_addr_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && $past(mem_rd || mem_wr))
            |-> (mem_addr == AW'($past(mem_addr) + AW'(1))));

    p_at_most_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |=> !(mem_rd || mem_wr));

    p_store_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ($stable(flag_n) && $stable(flag_z)));

    p_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && zero_q) |-> (mem_wdata == 8'h00));

endmodule

bind ldst_seq ldst_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .zero_q    (zero_q)
);

// File: tb/tb_ldst_seq.sv
module tb_ldst_seq;

    localparam int AW = 16;
    localparam int NV = 12;
    // {op[1:0], tgt[1:0], narrow, ea[15:0]}
    localparam logic [20:0] VEC [NV] = '{
        {2'b00, 2'b00, 1'b0, 16'h0010},  // wide load A
        {2'b00, 2'b01, 1'b1, 16'h0013},  // narrow load X
        {2'b01, 2'b00, 1'b0, 16'h0020},  // wide store A
        {2'b01, 2'b01, 1'b1, 16'h0022},  // narrow store X
        {2'b10, 2'b00, 1'b0, 16'h0024},  // wide store zero
        {2'b00, 2'b10, 1'b0, 16'h0030},  // wide load of zeros into Y
        {2'b00, 2'b00, 1'b1, 16'h003A},  // narrow load zero byte into A
        {2'b00, 2'b01, 1'b0, 16'hFFFF},  // wide load, wrapping
        {2'b01, 2'b00, 1'b0, 16'hFFFF},  // wide store, wrapping
        {2'b00, 2'b10, 1'b0, 16'h0020},  // read back stored A
        {2'b11, 2'b01, 1'b1, 16'h0011},  // narrow store zero
        {2'b00, 2'b00, 1'b1, 16'h0011}   // narrow load of zeroed byte
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = '0;
    logic [1:0]    tgt = '0;
    logic          narrow = 1'b1;
    logic [AW-1:0] ea = '0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          mem_rd, mem_wr, done;
    logic [15:0]   acc_q, x_q, y_q;
    logic          flag_n, flag_z;

    logic [7:0]  mem [64];
    logic [15:0] m_reg [3];
    logic        m_n, m_z;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    ldst_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tgt(tgt),
        .narrow(narrow), .ea(ea), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done),
        .acc_q(acc_q), .x_q(x_q), .y_q(y_q), .flag_n(flag_n), .flag_z(flag_z)
    );

    assign mem_rdata = mem[mem_addr[5:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " acc"}, 32'(acc_q), 32'(m_reg[0]));
        chk({req, " x"},   32'(x_q),   32'(m_reg[1]));
        chk({req, " y"},   32'(y_q),   32'(m_reg[2]));
        chk({req, " n"},   32'(flag_n), 32'(m_n));
        chk({req, " z"},   32'(flag_z), 32'(m_z));
    endtask

    task automatic do_op(input logic [1:0] o, input logic [1:0] t,
                         input logic nar, input logic [15:0] a);
        int          ri;
        logic [15:0] a1;
        logic [7:0]  b_lo, b_hi;
        logic [15:0] val;
        ri = t[1] ? 2 : int'(t[0]);
        a1 = a + 16'd1;
        @(negedge clk);
        start = 1'b1; op = o; tgt = t; narrow = nar; ea = a;
        @(negedge clk);
        start = 1'b0;
        b_lo = mem[a[5:0]];
        chk("R1 low address", 32'(mem_addr), 32'(a));
        chk("R2 read enable", 32'(mem_rd), 32'(o == 2'b00));
        chk("R2 write enable", 32'(mem_wr), 32'(o != 2'b00));
        if (o == 2'b01) chk("R7 low data", 32'(mem_wdata), 32'(m_reg[ri][7:0]));
        if (o[1])       chk("R8 zero low", 32'(mem_wdata), 32'h0);
        b_hi = 8'h00;
        if (!nar) begin
            @(negedge clk);
            b_hi = mem[a1[5:0]];
            chk("R3 high address", 32'(mem_addr), 32'(a1));
            chk("R2 second access", 32'(mem_rd || mem_wr), 32'h1);
            if (o == 2'b01) chk("R7 high data", 32'(mem_wdata), 32'(m_reg[ri][15:8]));
            if (o[1])       chk("R8 zero high", 32'(mem_wdata), 32'h0);
        end
        @(negedge clk);
        chk("R1 done pulse", 32'(done), 32'h1);
        chk("R1 no access at done", 32'(mem_rd || mem_wr), 32'h0);
        if (o == 2'b00) begin
            if (nar) begin
                m_reg[ri][7:0] = b_lo;   // R6 high byte kept
                m_n = b_lo[7];
                m_z = (b_lo == 8'h00);
            end else begin
                val = {b_hi, b_lo};
                m_reg[ri] = val;
                m_n = val[15];
                m_z = (val == 16'h0);
            end
            chk_state("R4 R5 R6 after load");
        end else begin
            chk_state("R7 R8 after store");
        end
        @(negedge clk);
        chk("R1 done single cycle", 32'(done), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29 + 131);
        mem[48] = 8'h00; mem[49] = 8'h00; mem[58] = 8'h00;
        for (int i = 0; i < 3; i++) m_reg[i] = 16'h0;
        m_n = 1'b0; m_z = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset rd", 32'(mem_rd), 32'h0);
        chk("R10 reset wr", 32'(mem_wr), 32'h0);
        chk("R10 reset done", 32'(done), 32'h0);
        chk_state("R10 reset regs");
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            do_op(VEC[v][20:19], VEC[v][18:17], VEC[v][16], VEC[v][15:0]);

        // R9: start held high while busy, with a different operation
        @(negedge clk);
        start = 1'b1; op = 2'b00; tgt = 2'b10; narrow = 1'b0; ea = 16'h0004;
        @(negedge clk);
        op = 2'b01; tgt = 2'b00; narrow = 1'b1; ea = 16'h0008;
        chk("R9 first address", 32'(mem_addr), 32'h4);
        chk("R9 read kept", 32'(mem_rd), 32'h1);
        @(negedge clk);
        chk("R9 second address", 32'(mem_addr), 32'h5);
        chk("R9 still reading", 32'(mem_rd), 32'h1);
        m_reg[2] = {mem[5], mem[4]};
        m_n = mem[5][7];
        m_z = ({mem[5], mem[4]} == 16'h0);
        @(negedge clk);
        start = 1'b0;
        chk("R9 done", 32'(done), 32'h1);
        chk_state("R9 result");
        @(negedge clk);
        chk("R9 no restart", 32'(mem_rd || mem_wr), 32'h0);
        chk("R9 idle no done", 32'(done), 32'h0);

        // R10: reset during an access
        @(negedge clk);
        start = 1'b1; op = 2'b00; tgt = 2'b00; narrow = 1'b0; ea = 16'h0001;
        @(negedge clk);
        start = 1'b0;
        chk("R10 access before reset", 32'(mem_rd), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) m_reg[i] = 16'h0;
        m_n = 1'b0; m_z = 1'b0;
        chk("R10 access dropped", 32'(mem_rd || mem_wr), 32'h0);
        chk("R10 no done", 32'(done), 32'h0);
        chk_state("R10 mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 stays idle", 32'(mem_rd || mem_wr || done), 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule